// File: doc/BRIEF.md
# Hex-Text Pixel Line Streamer

This block sends one line of 8-bit grayscale pixels from an on-chip buffer to a host computer over an asynchronous serial transmit wire. Each pixel goes out as two readable hexadecimal characters, so a plain terminal program can display and capture the line. Each line begins with an opening marker and ends with a closing marker, followed by a carriage return and line feed. Both markers lie outside the hex alphabet, so the host can find where each line starts and ends.

The host requests a line by causing any level change on its own transmit wire, which the block watches as `rx_in`. The block never decodes the received character: one rising or falling edge, after a two-flop synchronizer, starts one block. Edges that arrive while a line is being sent are dropped and are not queued. The block contains the bit-rate divider, the 8N1 shift register, the nibble-to-character conversion and the sequencing of pixel reads. Reads use a synchronous port with one cycle of latency.

The sequencer uses the states IDLE, OPEN, HI, LO, FETCH, CLOSE, CR, LF and DRAIN. The transitions are:
- IDLE to OPEN on a detected edge, which also reads pixel 0.
- OPEN to HI once the opening marker is handed to the shifter.
- HI to LO once the high-nibble character is handed over.
- LO to FETCH once the low-nibble character is handed over and pixels remain. FETCH issues the next read and returns to HI.
- LO to CLOSE after the last pixel.
- CLOSE to CR, then CR to LF, then LF to DRAIN, as each of those characters is handed over.
- DRAIN to IDLE once the shifter has gone idle.

Top module: `hexline_streamer`

## Requirements
- R1: Each character is framed as one low start bit, eight data bits least significant first and one high stop bit. Every bit lasts exactly CLKS_PER_BIT clocks, and `tx_out` rests high between characters.
- R2: A block is, in order: '<' (0x3C); two characters per pixel for addresses 0 to LINE_PIXELS-1; '>' (0x3E); CR (0x0D); LF (0x0A).
- R3: Each pixel is sent high nibble first. Nibble values 0 to 9 become 0x30 to 0x39, and values 10 to 15 become 0x41 to 0x46.
- R4: A rising or a falling edge on `rx_in` starts exactly one block.
- R5: Edges on `rx_in` while `busy` is high are ignored and not queued. No block follows the current one unless a new edge arrives after `busy` falls.
- R6: `busy` is high from the trigger until the stop bit of the final LF has been fully sent, and is low otherwise. While `busy` is low, `tx_out` is high.
- R7: `mem_rd_en` is a single-cycle pulse. Each block reads every address from 0 to LINE_PIXELS-1 once, in ascending order, and `mem_rd_data` is taken one cycle after the pulse.
- R8: While `rst_n` is low, `tx_out` is high and `busy` and `mem_rd_en` are low, even if reset cuts a block short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Host serial line; any edge requests a block |
| mem_rd_en | output | 1 | Pixel buffer read strobe |
| mem_addr | output | ADDR_W | Pixel buffer read address |
| mem_rd_data | input | 8 | Pixel byte, valid one cycle after the strobe |
| tx_out | output | 1 | Serial transmit line to the host |
| busy | output | 1 | High while a block is in progress |

## Verification
The assertions check rules that must hold on every cycle:
- Each data bit holds steady inside its period.
- A start bit follows every load of the shifter.
- The line rests high whenever the block is idle.
- The read strobe lasts one cycle and stays within the buffer range.
- A trigger seen in IDLE always raises `busy`.

Only the bench's scenarios can show the rest:
- The full content and order of characters in a line, including the hex mapping at the digit/letter boundary.
- The measured bit period.
- That edges during a block leave no pending request.
- Recovery after a reset in mid-line.

// File: rtl/hexline_pkg.sv
package hexline_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPEN,
        ST_HI,
        ST_LO,
        ST_FETCH,
        ST_CLOSE,
        ST_CR,
        ST_LF,
        ST_DRAIN
    } seq_state_e;

    localparam logic [7:0] CH_OPEN  = 8'h3C;
    localparam logic [7:0] CH_CLOSE = 8'h3E;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
endpackage

// File: rtl/rx_edge_trigger.sv
module rx_edge_trigger #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic edge_seen
);
    // sync_q[0..SYNC_STAGES-1] is the synchronizer; the top bit holds the previous level
    logic [SYNC_STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], rx_in};
        end
    end

    assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
    parameter int CLKS_PER_BIT = 868,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] data,
    output logic                 ready,
    output logic                 tx
);
    localparam int FRAME = DATA_BITS + 2;
    localparam int CW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int BW    = $clog2(FRAME + 1);

    logic             active;
    logic [FRAME-1:0] shreg;
    logic [CW-1:0]    baud;
    logic [BW-1:0]    bitcnt;
    logic             bit_end;

    assign bit_end = (baud == CW'(CLKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            shreg  <= '1;
            baud   <= '0;
            bitcnt <= '0;
        end else if (!active) begin
            if (load) begin
                shreg  <= {1'b1, data, 1'b0};
                active <= 1'b1;
                baud   <= '0;
                bitcnt <= '0;
            end
        end else if (bit_end) begin
            baud  <= '0;
            shreg <= {1'b1, shreg[FRAME-1:1]};
            if (bitcnt == BW'(FRAME - 1)) begin
                active <= 1'b0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end else begin
            baud <= baud + 1'b1;
        end
    end

    assign ready = !active;
    assign tx    = shreg[0];

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready) |=> !tx);

    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && baud != '0) |-> $stable(tx));
endmodule

// File: rtl/nibble_ascii.sv
module nibble_ascii (
    input  logic [3:0] nib,
    output logic [7:0] ch
);
    always_comb begin
        if (nib < 4'd10) begin
            ch = {4'h3, nib};
        end else begin
            ch = 8'h37 + {4'h0, nib};
        end
    end
endmodule

// File: rtl/hexline_streamer.sv
module hexline_streamer
    import hexline_pkg::*;
#(
    parameter int CLKS_PER_BIT = 868,
    parameter int LINE_PIXELS  = 1024,
    parameter int ADDR_W       = (LINE_PIXELS > 1) ? $clog2(LINE_PIXELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              tx_out,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(LINE_PIXELS - 1);

    seq_state_e        st, nxt;
    logic              trig;
    logic              tx_load, tx_ready;
    logic [7:0]        tx_byte;
    logic [ADDR_W-1:0] idx;
    logic              idx_inc, idx_clr;
    logic              rd_pend;
    logic [7:0]        pix_q;
    logic [7:0]        hex_ch [2];
    logic              last_pix;

    rx_edge_trigger #(.SYNC_STAGES(2)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .edge_seen(trig)
    );

    serial_tx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tx_load),
        .data (tx_byte),
        .ready(tx_ready),
        .tx   (tx_out)
    );

    // lane 0 converts the low nibble, lane 1 the high nibble
    for (genvar g = 0; g < 2; g++) begin : g_hex
        nibble_ascii u_nib (
            .nib(pix_q[4*g +: 4]),
            .ch (hex_ch[g])
        );
    end

    assign last_pix = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            rd_pend <= 1'b0;
            pix_q   <= '0;
        end else begin
            st      <= nxt;
            rd_pend <= mem_rd_en;
            if (rd_pend) begin
                pix_q <= mem_rd_data;
            end
            if (idx_clr) begin
                idx <= '0;
            end else if (idx_inc) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        nxt       = st;
        tx_load   = 1'b0;
        tx_byte   = '0;
        mem_rd_en = 1'b0;
        idx_inc   = 1'b0;
        idx_clr   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (trig) begin
                    mem_rd_en = 1'b1;
                    nxt       = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = CH_OPEN;
                    nxt     = ST_HI;
                end
            end
            ST_HI: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = hex_ch[1];
                    nxt     = ST_LO;
                end
            end
            ST_LO: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = hex_ch[0];
                    if (last_pix) begin
                        idx_clr = 1'b1;
                        nxt     = ST_CLOSE;
                    end else begin
                        idx_inc = 1'b1;
                        nxt     = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                mem_rd_en = 1'b1;
                nxt       = ST_HI;
            end
            ST_CLOSE: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = CH_CLOSE;
                    nxt     = ST_CR;
                end
            end
            ST_CR: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = CH_CR;
                    nxt     = ST_LF;
                end
            end
            ST_LF: begin
                if (tx_ready) begin
                    tx_load = 1'b1;
                    tx_byte = CH_LF;
                    nxt     = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (tx_ready) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign mem_addr = idx;
    assign busy     = (st != ST_IDLE);

    // R6
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < LINE_PIXELS));

    // R4
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy) |=> busy);
endmodule

// File: tb/test_hexline_streamer.sv
module test_hexline_streamer;
    localparam int CPB  = 8;
    localparam int NPIX = 4;
    localparam int NCH  = 2 * NPIX + 4;
    localparam int NLINES = 6;
    // pixel 0 is in bits [31:24]
    localparam logic [31:0] LINES [NLINES] = '{
        32'h00FF_9A5C, 32'hA90F_F012, 32'h3C3E_0D0A,
        32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_BCDE
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       mem_rd_en;
    logic [1:0] mem_addr;
    logic [7:0] mem_rd_data;
    logic       tx_out;
    logic       busy;

    logic [7:0] pix_mem [NPIX];
    int total = 0;
    int fails = 0;
    int cyc = 0;
    int rd_total = 0;
    int addr_err = 0;
    int rd_seq = 0;

    always #5 clk = ~clk;

    hexline_streamer #(.CLKS_PER_BIT(CPB), .LINE_PIXELS(NPIX)) i_hexline_streamer (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .tx_out(tx_out), .busy(busy)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= pix_mem[mem_addr];
            if (int'(mem_addr) != rd_seq) addr_err++;
            rd_seq = (rd_seq == NPIX - 1) ? 0 : rd_seq + 1;
            rd_total++;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(bit cond, string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] hexc(logic [3:0] n);
        return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n - 10);
    endfunction

    task automatic rx_char(output logic [7:0] ch, output bit ok);
        int t = 0;
        ok = 1;
        ch = '0;
        while (tx_out !== 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 4000) begin
            ok = 0;
            return;
        end
        repeat (CPB / 2) @(negedge clk);
        if (tx_out !== 1'b0) ok = 0;
        for (int b = 0; b < 8; b++) begin
            repeat (CPB) @(negedge clk);
            ch[b] = tx_out;
        end
        repeat (CPB) @(negedge clk);
        if (tx_out !== 1'b1) ok = 0;
    endtask

    task automatic load_line(logic [31:0] w);
        for (int i = 0; i < NPIX; i++) pix_mem[i] = w[31 - 8*i -: 8];
    endtask

    task automatic expect_line(logic [31:0] w, string req);
        logic [7:0] exp_c [NCH];
        logic [7:0] ch;
        bit ok;
        exp_c[0] = 8'h3C;
        for (int i = 0; i < NPIX; i++) begin
            exp_c[1 + 2*i] = hexc(w[31 - 8*i -: 4]);
            exp_c[2 + 2*i] = hexc(w[27 - 8*i -: 4]);
        end
        exp_c[NCH-3] = 8'h3E;
        exp_c[NCH-2] = 8'h0D;
        exp_c[NCH-1] = 8'h0A;
        for (int k = 0; k < NCH; k++) begin
            rx_char(ch, ok);
            check(ok && ch == exp_c[k], req, {23'd0, ok, ch}, {24'd0, exp_c[k]});
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 4000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        int low_cnt;
        int rd_before;
        bit stray;
        for (int i = 0; i < NPIX; i++) pix_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(tx_out === 1'b1, "R8 tx", 32'(tx_out), 1);
        check(busy === 1'b0, "R8 busy", 32'(busy), 0);
        check(mem_rd_en === 1'b0, "R8 rd", 32'(mem_rd_en), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // table walk: R2, R3 content; R4 alternating edge direction; R6 busy at end
        for (int L = 0; L < NLINES; L++) begin
            load_line(LINES[L]);
            rx_in = ~rx_in;
            expect_line(LINES[L], (L % 2 == 0) ? "R2/R3/R4 falling" : "R2/R3/R4 rising");
            check(busy === 1'b1, "R6 busy in last stop", 32'(busy), 1);
            repeat (CPB) @(negedge clk);
            check(busy === 1'b0 && tx_out === 1'b1, "R6 idle after", {busy, tx_out}, 32'b01);
        end
        // R7 reads
        check(rd_total == NLINES * NPIX, "R7 count", rd_total, NLINES * NPIX);
        check(addr_err == 0, "R7 order", addr_err, 0);

        // R1 bit period: '<' = 0x3C gives start + two zero bits low
        load_line(32'h1111_1111);
        rx_in = ~rx_in;
        while (tx_out !== 1'b0) @(negedge clk);
        low_cnt = 0;
        while (tx_out === 1'b0 && low_cnt < 1000) begin
            low_cnt++;
            @(negedge clk);
        end
        check(low_cnt == 3 * CPB, "R1 period", low_cnt, 3 * CPB);
        wait_idle();
        check(busy === 1'b0, "R1 finished", 32'(busy), 0);
        repeat (4) @(negedge clk);

        // R5: edges during a block are dropped
        load_line(32'h5A5A_C3C3);
        rd_before = rd_total;
        rx_in = ~rx_in;
        repeat (60) @(negedge clk);
        rx_in = ~rx_in;
        repeat (200) @(negedge clk);
        rx_in = ~rx_in;
        repeat (150) @(negedge clk);
        rx_in = ~rx_in;
        wait_idle();
        stray = 0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (busy !== 1'b0 || tx_out !== 1'b1) stray = 1;
        end
        check(!stray, "R5 no queued block", 32'(stray), 0);
        check(rd_total - rd_before == NPIX, "R5 reads", rd_total - rd_before, NPIX);

        // R8: reset in mid-line
        load_line(32'h0123_4567);
        rx_in = ~rx_in;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        rx_in = 1'b1;
        @(negedge clk);
        check(tx_out === 1'b1 && busy === 1'b0, "R8 mid reset", {busy, tx_out}, 32'b01);
        check(mem_rd_en === 1'b0, "R8 mid reset rd", 32'(mem_rd_en), 0);
        rd_seq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stray = 0;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (busy !== 1'b0) stray = 1;
        end
        check(!stray, "R8 quiet after reset", 32'(stray), 0);
        // a fresh block after reset is whole
        rx_in = 1'b0;
        expect_line(32'h0123_4567, "R2 after reset");
        wait_idle();

        summary();
        $finish;
    end
endmodule